// File: doc/BRIEF.md
# Register-Controlled Byte-Serial SPI Master

This block lets a host move bytes over a four-wire SPI link through three 8-bit registers in a 16-bit address space. The host holds the chip select itself: it pulls the select line low by writing the configuration register and releases it the same way. Transfers never touch the select line, so one select window can carry any number of bytes.

Each write to the command register sends that byte out, most significant bit first, in SPI mode 0. At the same time, the byte coming in on the input line is captured. To read from the flash, the host writes a dummy byte, usually 0x00, waits until the busy flag clears, and then reads the data register. A single flash transaction is expected to carry no more than 256 bytes in each direction. The block does not count bytes; the host keeps that limit.

The serial clock runs at the system clock divided by `SCLK_DIV`, which defaults to 4. One byte therefore takes 32 system cycles.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset, the configuration register (0xFEAD) reads 0x00, the data register (0xFEAB) reads 0x00, `spi_csn` is 1 and `spi_sclk` is 0.
- R2: A configuration write with bit 3 (write-enable) set copies written bit 4 to the select control: bit 4 = 1 drives `spi_csn` low and bit 4 = 0 drives it high. A configuration write with bit 3 clear leaves `spi_csn` unchanged. Bits 3 and 0 are stored from every configuration write.
- R3: An accepted command write (address 0xFEAC) makes the transfer busy from the next cycle for 32 cycles. Configuration bit 1 reads 1 during that time, provided bit 0 (status check enable) is set.
- R4: When configuration bit 0 is clear, configuration bit 1 reads 0 even while a transfer runs.
- R5: `spi_sclk` idles low and gives 8 pulses per byte, each SCLK_DIV system cycles long. `spi_mosi` carries the command byte MSB first and is stable at each rising edge.
- R6: `spi_miso` is sampled on each rising `spi_sclk` edge, MSB first. The assembled byte is readable at 0xFEAB once busy clears.
- R7: A command write while a transfer is busy is ignored. The running byte completes unchanged and no further byte starts.
- R8: Writes to the data register are ignored. Reads of any unmapped address return 0x00. Configuration bits 7:5 and 2 read 0.
- R9: Transfers run whatever the select level is, and they never change `spi_csn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_csn | output | 1 | Chip select, active low, held by software |

## Verification
A wrong bit counter or phase counter shows up first in the busy window: it differs from 32 cycles, and the bench sees this by reading the status bit one cycle before and one cycle after the expected end. It also shows up in the number of serial clock pulses, which the bench counts for each byte. A wrong shift direction or a misplaced sampling point shows up as soon as one transfer finishes, because the byte the model slave captured from `spi_mosi` differs from the byte written, or the data register differs from the byte the slave sent. A select control that ignores the write-enable guard shows on `spi_csn` in the cycle after the guarded write.

// File: rtl/spi_reg_pkg.sv
// Package: shared address map and configuration bit positions for the
// register-controlled SPI master. Assumes an 8-bit register width.
package spi_reg_pkg;
    localparam int ADDR_W = 16;
    localparam int REG_W  = 8;

    localparam logic [ADDR_W-1:0] ADDR_RXDATA = 16'hFEAB;
    localparam logic [ADDR_W-1:0] ADDR_CMD    = 16'hFEAC;
    localparam logic [ADDR_W-1:0] ADDR_CFG    = 16'hFEAD;

    localparam int BIT_SEL_LOW = 4;  // select held low
    localparam int BIT_SEL_WEN = 3;  // guard for select update
    localparam int BIT_BUSY    = 1;  // read-only transfer status
    localparam int BIT_CHK_EN  = 0;  // status check enable
endpackage

// File: rtl/spi_sclk_gen.sv
// Module: serial clock phase generator. While run is high, a phase
// counter walks 0..DIV-1. The first half of each period is low and the
// second half is high. A sample pulse marks the last low phase and a
// shift pulse marks the last high phase.
// Assumes DIV is even and at least 2.
module spi_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic sample_pulse,
    output logic shift_pulse
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] HALF = PH_W'(DIV / 2);
    localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;

    // Phase counter: advances while running, parks at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Clock level and edge markers derived from the phase.
    always_comb begin
        sclk         = run && (phase >= HALF);
        sample_pulse = run && (phase == HALF - 1'b1);
        shift_pulse  = run && (phase == LAST);
    end
endmodule

// File: rtl/spi_byte_shifter.sv
// Module: one-byte shift engine. A start while idle loads the transmit
// byte and runs BITS clock periods. The input line is sampled on each
// sample pulse and the transmit register moves on each shift pulse.
// done marks the final cycle of a byte.
module spi_byte_shifter #(
    parameter int BITS = 8,
    parameter int DIV  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            miso,
    output logic            busy,
    output logic            done,
    output logic            sclk,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    logic [BITS-1:0]  tx_q;
    logic [BITS-1:0]  rx_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             sample_pulse;
    logic             shift_pulse;

    spi_sclk_gen #(.DIV(DIV)) u_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (busy),
        .sclk         (sclk),
        .sample_pulse (sample_pulse),
        .shift_pulse  (shift_pulse)
    );

    // End of the last bit period.
    always_comb done = busy && shift_pulse && (bit_cnt == LAST_BIT);

    // Transfer control: load on start, advance the bit count, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            tx_q    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                bit_cnt <= '0;
                tx_q    <= tx_byte;
            end
        end else if (shift_pulse) begin
            tx_q    <= {tx_q[BITS-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            if (done) begin
                busy <= 1'b0;
            end
        end
    end

    // Receive register: gather input bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_pulse) begin
            rx_q <= {rx_q[BITS-2:0], miso};
        end
    end

    always_comb begin
        mosi    = busy && tx_q[BITS-1];
        rx_byte = rx_q;
    end
endmodule

// File: rtl/spi_ctrl_regs.sv
// Module: host register file. Decodes writes to the command and
// configuration registers, holds the select control and the received
// byte, and returns read data combinationally. Assumes one write strobe
// per register access.
module spi_ctrl_regs
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [REG_W-1:0]  rx_byte,
    output logic              cmd_start,
    output logic              sel_low
);
    logic             chk_en_q;
    logic             wen_q;
    logic [REG_W-1:0] data_q;
    logic             cfg_wr;

    always_comb begin
        cfg_wr    = reg_wr && (reg_addr == ADDR_CFG);
        cmd_start = reg_wr && (reg_addr == ADDR_CMD) && !busy;
    end

    // Configuration storage: the select bit is guarded by written bit 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en_q <= 1'b0;
            wen_q    <= 1'b0;
            sel_low  <= 1'b0;
        end else if (cfg_wr) begin
            chk_en_q <= reg_wdata[BIT_CHK_EN];
            wen_q    <= reg_wdata[BIT_SEL_WEN];
            if (reg_wdata[BIT_SEL_WEN]) begin
                sel_low <= reg_wdata[BIT_SEL_LOW];
            end
        end
    end

    // Received byte: captured when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done) begin
            data_q <= rx_byte;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_RXDATA) begin
            reg_rdata = data_q;
        end else if (reg_addr == ADDR_CFG) begin
            reg_rdata[BIT_SEL_LOW] = sel_low;
            reg_rdata[BIT_SEL_WEN] = wen_q;
            reg_rdata[BIT_BUSY]    = busy && chk_en_q;
            reg_rdata[BIT_CHK_EN]  = chk_en_q;
        end
    end
endmodule

// File: rtl/spi_reg_engine.sv
// Module: top of the register-controlled SPI master. Connects the host
// register file to the byte shifter. Chip select is a software-held
// level and is independent of transfers.
module spi_reg_engine
    import spi_reg_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_csn
);
    logic             busy;
    logic             done;
    logic             cmd_start;
    logic             sel_low;
    logic [REG_W-1:0] rx_byte;

    spi_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .cmd_start (cmd_start),
        .sel_low   (sel_low)
    );

    spi_byte_shifter #(.BITS(REG_W), .DIV(SCLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_start),
        .tx_byte (reg_wdata),
        .miso    (spi_miso),
        .busy    (busy),
        .done    (done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_byte (rx_byte)
    );

    // Select pin: active low, driven by the software-held control bit.
    always_comb spi_csn = !sel_low;
endmodule

// File: rtl/spi_reg_engine_chk.sv
// Module: property checker for spi_reg_engine, attached by bind.
module spi_reg_engine_chk
    import spi_reg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              spi_sclk,
    input logic              spi_csn,
    input logic              busy,
    input logic              done
);
    logic cmd_wr;
    logic cfg_wr;
    always_comb begin
        cmd_wr = reg_wr && (reg_addr == ADDR_CMD);
        cfg_wr = reg_wr && (reg_addr == ADDR_CFG);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (spi_csn && !spi_sclk));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(spi_csn));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr));

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !done) |=> busy);
endmodule

bind spi_reg_engine spi_reg_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .spi_sclk (spi_sclk),
    .spi_csn  (spi_csn),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_spi_reg_engine.sv
`timescale 1ns/1ps
module sim_spi_reg_engine;
    localparam logic [15:0] A_DATA = 16'hFEAB;
    localparam logic [15:0] A_CMD  = 16'hFEAC;
    localparam logic [15:0] A_CFG  = 16'hFEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        spi_sclk, spi_mosi, spi_csn;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] slave_byte = '0;
    int         slave_idx  = 0;
    logic [7:0] mosi_cap   = '0;
    int         pulses     = 0;
    logic       exp_sel    = 1'b0;
    logic       exp_wen    = 1'b0;
    logic       exp_chk    = 1'b0;
    logic [7:0] exp_data   = '0;

    always #2.5 clk = ~clk;

    spi_reg_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_csn(spi_csn)
    );

    // Mode 0 slave model: capture on rising edge, change on falling edge.
    always @(posedge spi_sclk) begin
        mosi_cap <= {mosi_cap[6:0], spi_mosi};
        pulses   <= pulses + 1;
    end
    always @(negedge spi_sclk) begin
        slave_idx = slave_idx + 1;
        if (slave_idx < 8) spi_miso = slave_byte[7 - slave_idx];
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] cfg_expect(input logic busy_now);
        cfg_expect = {3'b000, exp_sel, exp_wen, 1'b0, busy_now && exp_chk, exp_chk};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] d);
        wr(A_CFG, d);
        exp_chk = d[0];
        exp_wen = d[3];
        if (d[3]) exp_sel = d[4];
    endtask

    // One byte transfer with checks on timing, status and data.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] rxb);
        logic [7:0] v;
        logic       csn_before;
        csn_before = spi_csn;
        slave_byte = rxb; slave_idx = 0; spi_miso = rxb[7]; pulses = 0;
        wr(A_CMD, tx);
        rd(A_CFG, v);
        check("R3 status set after command", v, cfg_expect(1'b1));
        repeat (31) @(negedge clk);
        rd(A_CFG, v);
        check(exp_chk ? "R3 status held 32 cycles" : "R4 status masked", v, cfg_expect(1'b1));
        @(negedge clk);
        rd(A_CFG, v);
        check("R3 status clear after 32 cycles", v, cfg_expect(1'b0));
        check("R5 eight sclk pulses", pulses, 8);
        check("R5 mosi byte MSB first", mosi_cap, tx);
        exp_data = rxb;
        rd(A_DATA, v);
        check("R6 received byte", v, exp_data);
        check("R9 select untouched by transfer", spi_csn, csn_before);
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd7021));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CFG, v);  check("R1 config after reset", v, 8'h00);
        rd(A_DATA, v); check("R1 data after reset", v, 8'h00);
        check("R1 select high", spi_csn, 1'b1);
        check("R1 sclk low", spi_sclk, 1'b0);

        // R2 guarded select update
        cfg_write(8'h10);
        check("R2 select ignored without enable", spi_csn, 1'b1);
        cfg_write(8'h19);
        check("R2 select low with enable", spi_csn, 1'b0);
        rd(A_CFG, v); check("R2 config readback", v, cfg_expect(1'b0));
        cfg_write(8'h01);
        check("R2 select kept when enable clear", spi_csn, 1'b0);

        // Directed corner bytes
        xfer(8'h00, 8'hA5);
        xfer(8'hFF, 8'h00);
        xfer(8'h80, 8'h01);

        // R7 command while busy
        slave_byte = 8'h3C; slave_idx = 0; spi_miso = 1'b0; pulses = 0;
        wr(A_CMD, 8'h96);
        repeat (10) @(negedge clk);
        wr(A_CMD, 8'h0F);
        repeat (20) @(negedge clk);
        rd(A_CFG, v); check("R7 busy ends on time", v, cfg_expect(1'b0));
        check("R7 first byte intact", mosi_cap, 8'h96);
        rd(A_DATA, v); check("R7 received byte intact", v, 8'h3C);
        repeat (8) @(negedge clk);
        check("R7 no second byte", pulses, 8);
        exp_data = 8'h3C;

        // R8 data register write and unmapped reads
        wr(A_DATA, 8'h5A);
        rd(A_DATA, v); check("R8 data write ignored", v, exp_data);
        rd(16'h1234, v); check("R8 unmapped reads zero", v, 8'h00);
        cfg_write(8'hFF);
        rd(A_CFG, v); check("R8 reserved bits zero", v, 8'h19);

        // R4 status masked, select released, transfers still run (R9)
        cfg_write(8'h08);
        check("R2 select released", spi_csn, 1'b1);
        xfer(8'hC3, 8'h5E);

        // Random transfers with random check enable and select level
        for (int i = 0; i < 24; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            cfg_write(c & 8'h19);
            check("R2 select follows guarded write", spi_csn, !exp_sel);
            xfer(8'($urandom), 8'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule